// File: doc/BRIEF.md
# Serial receive queue with status

This block holds the bytes that a serial receiver produces before software or a DMA engine takes them. The bit-level deserializer sits upstream and delivers each byte as a one-cycle strobe, together with parity-error and frame-error flags for that byte and a separate line-break strobe. Software reaches the block through a small word-addressed register port. Reads return their data one cycle after the read strobe, and any side effect of a read takes place at that same edge.

The block has two receive modes. In queue mode, bytes go into a circular store of `DEPTH` entries. In single-register mode, each byte overwrites one holding register. The status word packs the receive fill count, a receive-full flag and the transmit-side count and full flag, which come in from outside. Two conditions raise a sticky error source: a byte lost because there was no room for it, and a data read from an empty queue. A separate error status register gathers overrun, parity, frame and break events and clears itself when read. A DMA-busy output tells the receive DMA engine that there is nothing to fetch.

Top module: `uart_rxq`

Register map (word address on `reg_addr_i`):

| Address | Contents |
|---|---|
| 0 | Control. Bit 0: queue mode enable. Bit 1: receive flush, self-clearing. Bit 2: transmit flush, self-clearing. Bits [5:4]: receive service mode. Bits 1 and 2 always read back as 0. |
| 1 | Line status. Bit 0: data ready. |
| 2 | Error status, cleared by a read. Bit 0: overrun. Bit 1: parity. Bit 2: frame. Bit 3: break. |
| 3 | Fill status. Bits [7:0]: receive count. Bit 8: receive full. Bits [23:16]: transmit count. Bit 24: transmit full. |
| 4 | Receive data. A read takes one byte. |
| 5 | Error source. Bit 0: pending. Writing 1 to bit 0 clears it. |

## Requirements
- R1: After reset, every register reads 0 and `err_src_o`, `dma_busy_o` and `tx_flush_o` are low.
- R2: In queue mode, data reads (address 4) return the bytes in the order they arrived. Fill status bits [7:0] hold the number of bytes stored.
- R3: When the queue holds `DEPTH` bytes, fill status reads bit 8 = 1 and bits [7:0] = 0. Below `DEPTH`, bit 8 is 0.
- R4: A byte that arrives while the queue is full is dropped. The queue keeps its contents, the error source is set and error status bit 0 (overrun) is set.
- R5: A data read from an empty queue in queue mode returns 0 and sets the error source.
- R6: Line status bit 0 is set by every received byte or break. In queue mode, a data read clears it only when that read empties the queue. A receive flush also clears it.
- R7: In single-register mode, each byte overwrites the holding register and any data read clears the ready bit. A byte that arrives while ready is already set, with no read in the same cycle, sets the overrun bit.
- R8: A break strobe stores a zero byte exactly like a received byte and sets error status bit 3.
- R9: A read of error status returns the bits gathered so far and clears them. Error status bit 1 records a parity error and bit 2 a frame error; each is taken only when it comes together with a byte strobe.
- R10: `dma_busy_o` is high exactly when control bits [5:4] equal binary 10 and the queue is empty.
- R11: A control write with bit 1 set empties the queue. A control write with bit 2 set gives a one-cycle pulse on `tx_flush_o` in the cycle after the write. Neither bit is stored.
- R12: When the queue is neither empty nor full, a byte arriving in the same cycle as a data read is accepted while the oldest byte is returned, and the count does not change.
- R13: Fill status bits [23:16] mirror `tx_count_i` and bit 24 mirrors `tx_full_i`.
- R14: The error source stays set until software writes 1 to bit 0 of address 5. If a new error occurs in the same cycle as that write, the error source stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Word address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle after the read strobe |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Line-break strobe |
| rx_perr_i | input | 1 | Parity error flag for the byte on this strobe |
| rx_ferr_i | input | 1 | Frame error flag for the byte on this strobe |
| tx_count_i | input | 8 | Transmit queue fill count |
| tx_full_i | input | 1 | Transmit queue full flag |
| tx_flush_o | output | 1 | Transmit flush pulse |
| err_src_o | output | 1 | Sticky error source |
| dma_busy_o | output | 1 | Receive DMA busy |

## Verification
All state changes at the clock edge where a strobe is sampled. `reg_rdata_o` carries the value read at that edge, as seen before any side effect, and is valid from the edge until the next read. `err_src_o` and `tx_flush_o` are registered, so each shows the result of a stimulus one edge after it. `dma_busy_o` is decoded from state and settles in that same cycle. The bench drives every stimulus just after a falling edge and samples every output at the next falling edge. A reference model in the bench advances by one edge per stimulus and predicts the outputs sampled there.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_LSTAT = 3'd1,
    RA_ERR   = 3'd2,
    RA_FSTAT = 3'd3,
    RA_DATA  = 3'd4,
    RA_ESRC  = 3'd5
  } reg_addr_e;

  localparam int unsigned CTRL_QEN    = 0;
  localparam int unsigned CTRL_RXFL   = 1;
  localparam int unsigned CTRL_TXFL   = 2;
  localparam int unsigned CTRL_MODE_L = 4;

  localparam int unsigned ERR_OVR = 0;
  localparam int unsigned ERR_PAR = 1;
  localparam int unsigned ERR_FRM = 2;
  localparam int unsigned ERR_BRK = 3;
  localparam int unsigned ERR_W   = 4;

  localparam logic [1:0] MODE_DMA = 2'b10;

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned DW    = 8,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
  logic          full_q;
  logic          do_push, do_pop;

  assign empty_o = ~full_q & (wr_ptr_q == rd_ptr_q);
  assign full_o  = full_q;
  assign do_push = push_i & ~full_q & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;

  assign wr_nxt = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + PW'(1);
  assign rd_nxt = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + PW'(1);

  always_comb begin
    if (full_q)                    count_o = CW'(DEPTH);
    else if (wr_ptr_q >= rd_ptr_q) count_o = CW'(wr_ptr_q - rd_ptr_q);
    else                           count_o = CW'(DEPTH) - CW'(rd_ptr_q) + CW'(wr_ptr_q);
  end

  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      full_q   <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      full_q   <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= wr_nxt;
      if (do_pop)  rd_ptr_q <= rd_nxt;
      if (do_push && !do_pop && (wr_nxt == rd_ptr_q)) full_q <= 1'b1;
      else if (do_pop && !do_push)                    full_q <= 1'b0;
    end
  end

  p_flush_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

  p_drop_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(wr_ptr_q) && $stable(rd_ptr_q));

  p_empty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !flush_i |=> empty_o);

  p_count_same_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o && !full_o && push_i && pop_i && !flush_i |=> $stable(count_o));

endmodule

// File: rtl/uart_rxq_err.sv
module uart_rxq_err
  import uart_rxq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ERR_W-1:0]  set_i,
  input  logic              rd_clr_i,
  input  logic              esrc_set_i,
  input  logic              esrc_clr_i,
  output logic [ERR_W-1:0]  stat_o,
  output logic              esrc_o
);

  logic [ERR_W-1:0] stat_q;
  logic             esrc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      esrc_q <= 1'b0;
    end else begin
      stat_q <= rd_clr_i ? set_i : (stat_q | set_i);
      if (esrc_set_i)      esrc_q <= 1'b1;
      else if (esrc_clr_i) esrc_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign esrc_o = esrc_q;

  p_err_rdclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i && (set_i == '0) |=> stat_o == '0);

  p_esrc_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esrc_o && !esrc_clr_i |=> esrc_o);

endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_ctrl_i,
  input  logic [31:0] wdata_i,
  input  logic        push_evt_i,
  input  logic [7:0]  push_byte_i,
  input  logic        data_rd_i,
  input  logic        q_last_i,
  output logic        qen_o,
  output logic [1:0]  mode_o,
  output logic        rx_flush_o,
  output logic        tx_flush_o,
  output logic        ready_o,
  output logic [7:0]  hold_o
);

  logic       qen_q, txfl_q, ready_q;
  logic [1:0] mode_q;
  logic [7:0] hold_q;
  logic       rd_clr;

  assign rx_flush_o = wr_ctrl_i & wdata_i[CTRL_RXFL];
  // queue mode: clear only when this read takes the last byte
  assign rd_clr = data_rd_i & (qen_q ? q_last_i : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qen_q   <= 1'b0;
      mode_q  <= '0;
      txfl_q  <= 1'b0;
      ready_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      txfl_q <= wr_ctrl_i & wdata_i[CTRL_TXFL];
      if (wr_ctrl_i) begin
        qen_q  <= wdata_i[CTRL_QEN];
        mode_q <= wdata_i[CTRL_MODE_L+:2];
      end
      if (!qen_q && push_evt_i) hold_q <= push_byte_i;
      if (rx_flush_o)      ready_q <= 1'b0;
      else if (push_evt_i) ready_q <= 1'b1;
      else if (rd_clr)     ready_q <= 1'b0;
    end
  end

  assign qen_o      = qen_q;
  assign mode_o     = mode_q;
  assign tx_flush_o = txfl_q;
  assign ready_o    = ready_q;
  assign hold_o     = hold_q;

  p_ready_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qen_o && data_rd_i && q_last_i && !push_evt_i && !rx_flush_o |=> !ready_o);

  p_ready_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qen_o && data_rd_i && !push_evt_i |=> !ready_o);

  p_txfl_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl_i |=> !tx_flush_o);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_break_i,
  input  logic        rx_perr_i,
  input  logic        rx_ferr_i,
  input  logic [7:0]  tx_count_i,
  input  logic        tx_full_i,
  output logic        tx_flush_o,
  output logic        err_src_o,
  output logic        dma_busy_o
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic             push_evt, data_rd, wr_ctrl, overrun, underflow;
  logic [7:0]       push_byte, q_rdata, hold, cnt8;
  logic             q_empty, q_full, q_push, q_pop;
  logic [CW-1:0]    q_count;
  logic             qen, rx_flush, ready;
  logic [1:0]       mode;
  logic [ERR_W-1:0] err_set, err_stat;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;

  assign push_evt  = rx_valid_i | rx_break_i;
  assign push_byte = rx_break_i ? 8'h00 : rx_data_i;
  assign data_rd   = reg_rd_i & (reg_addr_i == RA_DATA);
  assign wr_ctrl   = reg_wr_i & (reg_addr_i == RA_CTRL);
  assign q_push    = qen & push_evt;
  assign q_pop     = qen & data_rd;

  uart_rxq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr_ctrl),
    .wdata_i     (reg_wdata_i),
    .push_evt_i  (push_evt),
    .push_byte_i (push_byte),
    .data_rd_i   (data_rd),
    .q_last_i    (q_count == CW'(1)),
    .qen_o       (qen),
    .mode_o      (mode),
    .rx_flush_o  (rx_flush),
    .tx_flush_o  (tx_flush_o),
    .ready_o     (ready),
    .hold_o      (hold)
  );

  uart_rxq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .wdata_i (push_byte),
    .pop_i   (q_pop),
    .flush_i (rx_flush),
    .rdata_o (q_rdata),
    .empty_o (q_empty),
    .full_o  (q_full),
    .count_o (q_count)
  );

  assign overrun   = qen ? (push_evt & q_full) : (push_evt & ready & ~data_rd);
  assign underflow = q_pop & q_empty;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = overrun;
    err_set[ERR_PAR] = rx_valid_i & rx_perr_i;
    err_set[ERR_FRM] = rx_valid_i & rx_ferr_i;
    err_set[ERR_BRK] = rx_break_i;
  end

  uart_rxq_err u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (err_set),
    .rd_clr_i   (reg_rd_i & (reg_addr_i == RA_ERR)),
    .esrc_set_i (overrun | underflow),
    .esrc_clr_i (reg_wr_i & (reg_addr_i == RA_ESRC) & reg_wdata_i[0]),
    .stat_o     (err_stat),
    .esrc_o     (err_src_o)
  );

  // full queue reports a zero count field plus the full bit
  assign cnt8 = q_full ? 8'h00 : 8'(q_count);

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      RA_CTRL: begin
        rd_mux[CTRL_QEN]       = qen;
        rd_mux[CTRL_MODE_L+:2] = mode;
      end
      RA_LSTAT: rd_mux[0] = ready;
      RA_ERR:   rd_mux[ERR_W-1:0] = err_stat;
      RA_FSTAT: rd_mux = {7'b0, tx_full_i, tx_count_i, 7'b0, q_full, cnt8};
      RA_DATA:  rd_mux[7:0] = qen ? (q_empty ? 8'h00 : q_rdata) : hold;
      RA_ESRC:  rd_mux[0] = err_src_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign dma_busy_o  = (mode == MODE_DMA) & q_empty;

  p_underflow_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qen && data_rd && q_empty |=> reg_rdata_o == 32'h0 && err_src_o);

  p_overflow_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qen && push_evt && q_full |=> err_src_o && err_stat[ERR_OVR]);

  p_break_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_break_i |=> err_stat[ERR_BRK] && ready);

endmodule

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0, rx_break = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  tx_count = '0;
  logic        tx_full = 1'b0;
  logic        tx_flush, err_src, dma_busy;

  always #10 clk = ~clk;

  uart_rxq #(.DEPTH(DEPTH)) u_uart_rxq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr),
    .tx_count_i(tx_count), .tx_full_i(tx_full),
    .tx_flush_o(tx_flush), .err_src_o(err_src), .dma_busy_o(dma_busy)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit         m_qen, m_ready, m_esrc, m_txf;
  bit [1:0]   m_mode;
  bit [7:0]   m_hold;
  bit [3:0]   m_err;
  bit [7:0]   m_q[$];
  bit [31:0]  m_exp;
  bit         m_rd;
  bit [2:0]   m_rd_addr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R11 ctrl readback";
      3'd1: return "R6 line status";
      3'd2: return "R9 error status";
      3'd3: return "R2 fill status";
      3'd4: return "R2 data";
      default: return "R14 error source";
    endcase
  endfunction

  function automatic bit [31:0] readval(input logic [2:0] a);
    int cnt = m_q.size();
    bit full = (cnt == DEPTH);
    case (a)
      3'd0: return {26'b0, m_mode, 3'b000, m_qen};
      3'd1: return {31'b0, m_ready};
      3'd2: return {28'b0, m_err};
      3'd3: return {7'b0, tx_full, tx_count, 7'b0, full, full ? 8'h00 : 8'(cnt)};
      3'd4: return m_qen ? ((cnt == 0) ? 32'h0 : {24'b0, m_q[0]}) : {24'b0, m_hold};
      3'd5: return {31'b0, m_esrc};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model();
    int  cnt = m_q.size();
    bit  full = (cnt == DEPTH);
    bit  empty = (cnt == 0);
    bit  drd = reg_rd && (reg_addr == 3'd4);
    bit  pev = rx_valid || rx_break;
    bit [7:0] b = rx_break ? 8'h00 : rx_data;
    bit  flush = reg_wr && (reg_addr == 3'd0) && reg_wdata[1];
    bit  ovr = m_qen ? (pev && full) : (pev && m_ready && !drd);
    bit  und = m_qen && drd && empty;
    bit [3:0] setb = {rx_break, rx_valid & rx_ferr, rx_valid & rx_perr, ovr};
    m_rd = reg_rd;
    m_rd_addr = reg_addr;
    if (reg_rd) m_exp = readval(reg_addr);
    if (flush) m_q.delete();
    else if (m_qen) begin
      if (drd && !empty) void'(m_q.pop_front());
      if (pev && !full) m_q.push_back(b);
    end
    if (!m_qen && pev) m_hold = b;
    if (flush) m_ready = 0;
    else if (pev) m_ready = 1;
    else if (drd && (m_qen ? (cnt == 1) : 1'b1)) m_ready = 0;
    if (reg_rd && reg_addr == 3'd2) m_err = setb; else m_err = m_err | setb;
    if (ovr || und) m_esrc = 1;
    else if (reg_wr && reg_addr == 3'd5 && reg_wdata[0]) m_esrc = 0;
    m_txf = reg_wr && (reg_addr == 3'd0) && reg_wdata[2];
    if (reg_wr && reg_addr == 3'd0) begin
      m_qen = reg_wdata[0];
      m_mode = reg_wdata[5:4];
    end
  endtask

  task automatic idle_in();
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 0; rx_data = '0; rx_break = 0; rx_perr = 0; rx_ferr = 0;
  endtask

  // inputs already driven; one edge, then compare at the falling edge
  task automatic step();
    @(posedge clk); #1; model();
    @(negedge clk);
    check("R10 dma busy", {31'b0, dma_busy}, {31'b0, (m_mode == 2'b10) && (m_q.size() == 0)});
    check("R14 error source", {31'b0, err_src}, {31'b0, m_esrc});
    check("R11 tx flush", {31'b0, tx_flush}, {31'b0, m_txf});
    if (m_rd) check(tag_of(m_rd_addr), reg_rdata, m_exp);
    idle_in();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v; step();
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_rd = 1; reg_addr = a; step(); v = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_data = b; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 dma busy", {31'b0, dma_busy}, 32'h0);
    check("R1 error source", {31'b0, err_src}, 32'h0);
    check("R1 tx flush", {31'b0, tx_flush}, 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, 32'h0);
    end

    // R2 order and count
    wr(3'd0, 32'h1);
    push(8'h11); push(8'h22); push(8'h33);
    rd(3'd3, v); check("R2 count", v, 32'd3);
    rd(3'd1, v); check("R6 ready after receive", v, 32'h1);
    rd(3'd4, v); check("R2 first byte", v, 32'h11);
    rd(3'd1, v); check("R6 ready kept", v, 32'h1);
    rd(3'd4, v); check("R2 second byte", v, 32'h22);
    rd(3'd4, v); check("R2 third byte", v, 32'h33);
    rd(3'd1, v); check("R6 ready cleared on empty", v, 32'h0);

    // R5 underflow, R14 clear
    rd(3'd4, v); check("R5 underflow data", v, 32'h0);
    check("R5 underflow source", {31'b0, err_src}, 32'h1);
    wr(3'd5, 32'h1);
    check("R14 source cleared", {31'b0, err_src}, 32'h0);

    // R3 full, R4 overflow
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
    rd(3'd3, v); check("R3 full status", v, 32'h100);
    check("R4 no error before overflow", {31'b0, err_src}, 32'h0);
    push(8'h99);
    check("R4 overflow source", {31'b0, err_src}, 32'h1);
    rd(3'd2, v); check("R4 overrun bit", v, 32'h1);
    rd(3'd2, v); check("R9 cleared on read", v, 32'h0);
    rd(3'd3, v); check("R4 queue kept full", v, 32'h100);
    rd(3'd4, v); check("R4 oldest kept", v, 32'h40);
    rd(3'd3, v); check("R3 count below depth", v, 32'd15);

    // R11 flush
    wr(3'd0, 32'h3);
    rd(3'd3, v); check("R11 flush empties", v, 32'h0);
    rd(3'd0, v); check("R11 flush bit not stored", v, 32'h1);
    rd(3'd1, v); check("R6 flush clears ready", v, 32'h0);

    // R12 simultaneous push and pop
    wr(3'd5, 32'h1);
    for (int i = 0; i < 5; i++) push(8'(8'h50 + i));
    rx_valid = 1; rx_data = 8'h60; reg_rd = 1; reg_addr = 3'd4; step();
    check("R12 pop data", reg_rdata, 32'h50);
    rd(3'd3, v); check("R12 count unchanged", v, 32'd5);

    // R8 break, R9 parity/frame
    rx_break = 1; step();
    rd(3'd3, v); check("R8 break stored", v, 32'd6);
    rd(3'd2, v); check("R8 break bit", v, 32'h8);
    rx_valid = 1; rx_data = 8'h77; rx_perr = 1; rx_ferr = 1; step();
    rx_perr = 1; rx_ferr = 1; step();
    rd(3'd2, v); check("R9 parity and frame", v, 32'h6);
    for (int i = 0; i < 5; i++) rd(3'd4, v);
    rd(3'd4, v); check("R8 zero byte", v, 32'h0);
    rd(3'd4, v); check("R8 byte after break", v, 32'h77);

    // R10 DMA busy
    wr(3'd0, 32'h21);
    check("R10 busy when empty", {31'b0, dma_busy}, 32'h1);
    push(8'h12);
    check("R10 idle with data", {31'b0, dma_busy}, 32'h0);
    rd(3'd4, v);
    check("R10 busy again", {31'b0, dma_busy}, 32'h1);
    wr(3'd0, 32'h11);
    check("R10 other mode", {31'b0, dma_busy}, 32'h0);

    // R7 single-register mode
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h1);
    push(8'hA5);
    rd(3'd1, v); check("R7 ready set", v, 32'h1);
    rd(3'd4, v); check("R7 holding data", v, 32'hA5);
    rd(3'd1, v); check("R7 read clears ready", v, 32'h0);
    rd(3'd2, v);
    push(8'h11); push(8'h22);
    rd(3'd2, v); check("R7 overwrite overrun", v, 32'h1);
    rd(3'd4, v); check("R7 latest byte", v, 32'h22);

    // R13 tx fields, R11 tx flush pulse
    tx_count = 8'h2A; tx_full = 1;
    rd(3'd3, v); check("R13 tx fields", v, 32'h012A0000);
    wr(3'd0, 32'h4);
    check("R11 tx flush pulse", {31'b0, tx_flush}, 32'h1);
    step();
    check("R11 tx flush ends", {31'b0, tx_flush}, 32'h0);
    rd(3'd0, v); check("R11 tx bit not stored", v, 32'h0);

    // random mix against the model
    wr(3'd0, 32'h1);
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      tx_count = 8'($urandom);
      tx_full = 1'($urandom);
      if (r < 3) begin
        reg_wr = 1; reg_addr = 3'd0;
        reg_wdata = '0;
        reg_wdata[0] = (($urandom % 4) != 0);
        reg_wdata[1] = (($urandom % 5) == 0);
        reg_wdata[2] = 1'($urandom);
        reg_wdata[5:4] = 2'($urandom);
      end else begin
        if (r < 6) begin reg_wr = 1; reg_addr = 3'd5; reg_wdata = 32'h1; end
        if (($urandom % 100) < 45) begin
          reg_rd = 1;
          reg_addr = (($urandom % 2) == 0) ? 3'd4 : 3'($urandom % 6);
          if (reg_wr) reg_addr = 3'd5;
        end
        if (($urandom % 100) < 45) begin
          rx_valid = 1; rx_data = 8'($urandom);
          rx_perr = (($urandom % 10) == 0);
          rx_ferr = (($urandom % 10) == 0);
        end else if (($urandom % 100) < 4) rx_break = 1;
      end
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule